// File: doc/BRIEF.md
# Processor Supervisor Reset Controller

This block supervises a microprocessor from digitized supply status. Three supply flags arrive as logic levels: supply good, early power-fail warning and a low-power (sleep) request. A watchdog strobe and a pushbutton also come in. From these the block drives a reset pair (active-high and active-low), a non-maskable interrupt, a power-fail pair and a gated active-low chip enable for a memory that must not be written while the supply is lost.

A policy input picks how power loss is handled. With the input low, the processor is assumed not to be battery backed. The interrupt then follows the early warning, and reset is held for the whole outage plus a start-up stretch. With the input high, the processor is assumed to be battery backed. The early warning then yields one fixed-width interrupt pulse so the processor can go to sleep. No reset is issued on power-down, but a start-up reset is still issued when the supply comes back.

Every asynchronous input except the chip enable passes through a two-flop synchronizer. All outputs are registered. Every duration is a parameter in clock cycles.

Top module: `supv_reset_ctrl`

## Requirements
- R1: `reset_o` and `reset_n_o` are complementary in every cycle. `pfail_o` and `pfail_n_o` are also complementary in every cycle.
- R2: While `rst` is high and on the first cycle after it, the outputs are `reset_o`=1, `nmi_o`=0, `pfail_o`=1 and `cen_o`=1.
- R3: With `batt_mode_i`=0, `reset_o` is 1 for the whole time the supply is reported bad. It stays 1 for a further `POR_CYC` cycles after supply good is seen, then returns to 0.
- R4: With `batt_mode_i`=1, loss of supply raises no reset. On supply return, `reset_o` is high for exactly `POR_CYC` consecutive cycles.
- R5: With `batt_mode_i`=0, `nmi_o` follows the level of `early_fail_i` after the synchronizer delay, so it is high for as many cycles as the warning is.
- R6: With `batt_mode_i`=1, each rising edge of `early_fail_i` produces exactly one `nmi_o` pulse of `NMI_CYC` cycles.
- R7: Only a high-to-low transition of `strobe_i` restarts the watchdog. A strobe held low does not prevent expiry.
- R8: When `WDOG_CYC` cycles pass without a strobe falling edge (while the supply is good, no reset is active and no sleep is requested), `reset_o` pulses high for exactly `WDRST_CYC` cycles. The watchdog count then restarts.
- R9: A `button_i` press shorter than `DEBOUNCE_CYC` cycles has no effect. A longer press holds `reset_o` high for as many cycles as the press lasts.
- R10: `pfail_o` is 1 while the supply is in its failed state and 0 otherwise.
- R11: While the supply is failed, `cen_o` is forced to 1 (inactive). Otherwise it is a one-cycle registered copy of `cen_i`.
- R12: While `sleep_req_i` is high, the watchdog does not count and cannot cause a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_good_i | input | 1 | Primary supply within range |
| early_fail_i | input | 1 | Early power-fail warning |
| sleep_req_i | input | 1 | Low-power request, halts the watchdog |
| batt_mode_i | input | 1 | Policy select: 0 not battery backed, 1 battery backed |
| strobe_i | input | 1 | Watchdog strobe, falling edge restarts the count |
| button_i | input | 1 | Pushbutton, active high, bouncing |
| cen_i | input | 1 | Chip enable in, active low |
| reset_o | output | 1 | Reset, active high |
| reset_n_o | output | 1 | Reset, active low |
| nmi_o | output | 1 | Non-maskable interrupt, active high |
| pfail_o | output | 1 | Power failed, active high |
| pfail_n_o | output | 1 | Power failed, active low |
| cen_o | output | 1 | Gated chip enable, active low |

## Verification
The bench aims at the policy split, because a design that confused the modes would reset a battery-backed processor on power loss or fail to hold a non-backed one in reset. It measures the start-up stretch and the interrupt pulse as exact cycle counts, so an off-by-one counter shows up as a wrong width. A strobe parked low must still let the watchdog expire; a design that restarted on a level would never reset there. Two-cycle button presses and a long sleep request must cause no reset; a missing debounce or a watchdog that ignores sleep would produce a stray pulse.

// File: rtl/supv_pkg.sv
`timescale 1ns/1ps
package supv_pkg;
  typedef enum logic [1:0] {
    PWR_OFF     = 2'd0,
    PWR_STRETCH = 2'd1,
    PWR_RUN     = 2'd2
  } pwr_state_t;

  localparam int SYNC_W    = 6;
  localparam int IX_GOOD   = 0;
  localparam int IX_EARLY  = 1;
  localparam int IX_SLEEP  = 2;
  localparam int IX_MODE   = 3;
  localparam int IX_STROBE = 4;
  localparam int IX_BUTTON = 5;
endpackage

// File: rtl/supv_sync.sv
`timescale 1ns/1ps
module supv_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_i[b];
        stab_q <= meta_q;
      end
    end
    assign q_o[b] = stab_q;
  end
endmodule

// File: rtl/supv_debounce.sv
`timescale 1ns/1ps
module supv_debounce #(
  parameter int DEB_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clean_o <= 1'b0;
      cnt_q   <= '0;
    end else if (raw_i == clean_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DEB_CYC - 1)) begin
      clean_o <= raw_i;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/supv_power_seq.sv
`timescale 1ns/1ps
module supv_power_seq
  import supv_pkg::*;
#(
  parameter int POR_CYC = 200,
  parameter int NMI_CYC = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       good_i,
  input  logic       early_i,
  output pwr_state_t state_o,
  output logic       nmi_pulse_o
);
  localparam int PW = (POR_CYC > 1) ? $clog2(POR_CYC) : 1;
  localparam int NW = $clog2(NMI_CYC + 1);

  logic [PW-1:0] por_cnt_q;
  logic [NW-1:0] nmi_cnt_q;
  logic          early_prev_q;
  logic          early_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o   <= PWR_OFF;
      por_cnt_q <= '0;
    end else begin
      unique case (state_o)
        PWR_OFF: begin
          if (good_i) begin
            state_o   <= PWR_STRETCH;
            por_cnt_q <= '0;
          end
        end
        PWR_STRETCH: begin
          if (!good_i) begin
            state_o <= PWR_OFF;
          end else if (por_cnt_q == PW'(POR_CYC - 1)) begin
            state_o <= PWR_RUN;
          end else begin
            por_cnt_q <= por_cnt_q + 1'b1;
          end
        end
        default: begin
          if (!good_i) state_o <= PWR_OFF;
        end
      endcase
    end
  end

  assign early_rise = early_i & ~early_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      early_prev_q <= 1'b0;
      nmi_cnt_q    <= '0;
    end else begin
      early_prev_q <= early_i;
      if (early_rise) begin
        nmi_cnt_q <= NW'(NMI_CYC);
      end else if (nmi_cnt_q != '0) begin
        nmi_cnt_q <= nmi_cnt_q - 1'b1;
      end
    end
  end

  assign nmi_pulse_o = (nmi_cnt_q != '0);
endmodule

// File: rtl/supv_watchdog.sv
`timescale 1ns/1ps
module supv_watchdog #(
  parameter int WD_CYC    = 1000,
  parameter int PULSE_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic hold_i,
  output logic expire_o,
  output logic busy_o
);
  localparam int WW = (WD_CYC > 1) ? $clog2(WD_CYC) : 1;
  localparam int RW = $clog2(PULSE_CYC + 1);

  logic          strobe_prev_q;
  logic          strobe_fall;
  logic [WW-1:0] wd_cnt_q;
  logic [RW-1:0] pulse_cnt_q;

  assign strobe_fall = strobe_prev_q & ~strobe_i;
  assign expire_o    = ~hold_i & ~strobe_fall & (wd_cnt_q == WW'(WD_CYC - 1));
  assign busy_o      = (pulse_cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_prev_q <= 1'b0;
      wd_cnt_q      <= '0;
      pulse_cnt_q   <= '0;
    end else begin
      strobe_prev_q <= strobe_i;
      if (hold_i || strobe_fall || expire_o) begin
        wd_cnt_q <= '0;
      end else begin
        wd_cnt_q <= wd_cnt_q + 1'b1;
      end
      if (expire_o) begin
        pulse_cnt_q <= RW'(PULSE_CYC);
      end else if (pulse_cnt_q != '0) begin
        pulse_cnt_q <= pulse_cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/supv_reset_ctrl.sv
`timescale 1ns/1ps
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 16,
  parameter int WDOG_CYC     = 1000,
  parameter int POR_CYC      = 200,
  parameter int NMI_CYC      = 32,
  parameter int WDRST_CYC    = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_good_i,
  input  logic early_fail_i,
  input  logic sleep_req_i,
  input  logic batt_mode_i,
  input  logic strobe_i,
  input  logic button_i,
  input  logic cen_i,
  output logic reset_o,
  output logic reset_n_o,
  output logic nmi_o,
  output logic pfail_o,
  output logic pfail_n_o,
  output logic cen_o
);
  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_in;
  logic good_s, early_s, sleep_s, mode_s, strobe_s, button_s;
  logic btn_db;
  pwr_state_t pwr_state;
  logic nmi_pulse;
  logic wd_hold;
  logic wd_expire;
  logic pulse_busy;
  logic supply_off;
  logic policy_rst;
  logic reset_req;

  always_comb begin
    raw_in            = '0;
    raw_in[IX_GOOD]   = supply_good_i;
    raw_in[IX_EARLY]  = early_fail_i;
    raw_in[IX_SLEEP]  = sleep_req_i;
    raw_in[IX_MODE]   = batt_mode_i;
    raw_in[IX_STROBE] = strobe_i;
    raw_in[IX_BUTTON] = button_i;
  end

  supv_sync #(.WIDTH(SYNC_W)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (sync_in)
  );

  assign good_s   = sync_in[IX_GOOD];
  assign early_s  = sync_in[IX_EARLY];
  assign sleep_s  = sync_in[IX_SLEEP];
  assign mode_s   = sync_in[IX_MODE];
  assign strobe_s = sync_in[IX_STROBE];
  assign button_s = sync_in[IX_BUTTON];

  supv_debounce #(.DEB_CYC(DEBOUNCE_CYC)) deb_i (
    .clk     (clk),
    .rst     (rst),
    .raw_i   (button_s),
    .clean_o (btn_db)
  );

  supv_power_seq #(.POR_CYC(POR_CYC), .NMI_CYC(NMI_CYC)) pwr_i (
    .clk         (clk),
    .rst         (rst),
    .good_i      (good_s),
    .early_i     (early_s),
    .state_o     (pwr_state),
    .nmi_pulse_o (nmi_pulse)
  );

  assign wd_hold = reset_o | ~good_s | sleep_s;

  supv_watchdog #(.WD_CYC(WDOG_CYC), .PULSE_CYC(WDRST_CYC)) wd_i (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe_s),
    .hold_i   (wd_hold),
    .expire_o (wd_expire),
    .busy_o   (pulse_busy)
  );

  assign supply_off = (pwr_state == PWR_OFF);
  assign policy_rst = mode_s ? (pwr_state == PWR_STRETCH) : (pwr_state != PWR_RUN);
  assign reset_req  = policy_rst | btn_db | pulse_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_o   <= 1'b1;
      reset_n_o <= 1'b0;
      nmi_o     <= 1'b0;
      pfail_o   <= 1'b1;
      pfail_n_o <= 1'b0;
      cen_o     <= 1'b1;
    end else begin
      reset_o   <= reset_req;
      reset_n_o <= ~reset_req;
      nmi_o     <= mode_s ? nmi_pulse : early_s;
      pfail_o   <= supply_off;
      pfail_n_o <= ~supply_off;
      cen_o     <= supply_off | cen_i;
    end
  end
endmodule

// File: rtl/supv_reset_chk.sv
`timescale 1ns/1ps
module supv_reset_chk #(
  parameter int NMI_CYC = 32
) (
  input logic clk,
  input logic rst,
  input logic reset_o,
  input logic reset_n_o,
  input logic pfail_o,
  input logic pfail_n_o,
  input logic nmi_o,
  input logic cen_o,
  input logic mode_s,
  input logic btn_db,
  input logic pulse_busy,
  input logic wd_expire
);
  localparam int RW = $clog2(NMI_CYC + 2);
  logic          mode_q, db_q, busy_q;
  logic [RW-1:0] nmi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      db_q    <= 1'b0;
      busy_q  <= 1'b0;
      nmi_run <= '0;
    end else begin
      mode_q <= mode_s;
      db_q   <= btn_db;
      busy_q <= pulse_busy;
      if (!mode_s || !nmi_o) nmi_run <= '0;
      else if (nmi_run != RW'(NMI_CYC + 1)) nmi_run <= nmi_run + 1'b1;
    end
  end

  assert_reset_pair_R1: assert property (@(posedge clk) disable iff (rst)
    (reset_o != reset_n_o) && (pfail_o != pfail_n_o));

  assert_hold_on_loss_R3: assert property (@(posedge clk) disable iff (rst)
    (pfail_o && !mode_q) |-> reset_o);

  assert_no_pd_reset_R4: assert property (@(posedge clk) disable iff (rst)
    (pfail_o && mode_q && !db_q && !busy_q) |-> !reset_o);

  assert_nmi_width_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_s && nmi_o) |-> (nmi_run < RW'(NMI_CYC)));

  assert_wd_reset_R8: assert property (@(posedge clk) disable iff (rst)
    wd_expire |-> ##2 reset_o);

  assert_cen_gate_R11: assert property (@(posedge clk) disable iff (rst)
    pfail_o |-> cen_o);
endmodule

bind supv_reset_ctrl supv_reset_chk #(.NMI_CYC(NMI_CYC)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .reset_o    (reset_o),
  .reset_n_o  (reset_n_o),
  .pfail_o    (pfail_o),
  .pfail_n_o  (pfail_n_o),
  .nmi_o      (nmi_o),
  .cen_o      (cen_o),
  .mode_s     (mode_s),
  .btn_db     (btn_db),
  .pulse_busy (pulse_busy),
  .wd_expire  (wd_expire)
);

// File: tb/supv_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module supv_reset_ctrl_tb_top;
  localparam int DEB = 4;
  localparam int WD  = 40;
  localparam int POR = 8;
  localparam int NMW = 5;
  localparam int WRP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_good = 1'b0, early_fail = 1'b0, sleep_req = 1'b0;
  logic batt_mode = 1'b0, strobe = 1'b1, button = 1'b0, cen_in = 1'b1;
  logic reset_o, reset_n_o, nmi_o, pfail_o, pfail_n_o, cen_o;
  logic kick_en = 1'b0, park_level = 1'b1;
  int   kick_cnt = 0;
  int   checks = 0, errors = 0;
  int   cycles = 0;
  bit   armed = 0;
  string phase = "R2";

  always #2.5 clk = ~clk;

  supv_reset_ctrl #(
    .DEBOUNCE_CYC(DEB), .WDOG_CYC(WD), .POR_CYC(POR), .NMI_CYC(NMW), .WDRST_CYC(WRP)
  ) dut_i (
    .clk(clk), .rst(rst), .supply_good_i(supply_good), .early_fail_i(early_fail),
    .sleep_req_i(sleep_req), .batt_mode_i(batt_mode), .strobe_i(strobe),
    .button_i(button), .cen_i(cen_in),
    .reset_o(reset_o), .reset_n_o(reset_n_o), .nmi_o(nmi_o),
    .pfail_o(pfail_o), .pfail_n_o(pfail_n_o), .cen_o(cen_o)
  );

  // strobe generator: a falling edge every 20 cycles when enabled
  always @(negedge clk) begin
    if (kick_en) begin
      kick_cnt <= kick_cnt + 1;
      if (kick_cnt % 10 == 9) strobe <= ~strobe;
    end else begin
      strobe <= park_level;
    end
  end

  // behavioural reference: queue delay line plus integer counters
  logic [5:0] dq[$];
  logic [5:0] sv = '0;
  int  m_db, m_dcnt, m_st, m_scnt, m_pe, m_ncnt, m_ps, m_wcnt, m_pcnt;
  logic e_rst, e_nmi, e_pf, e_cen;

  always @(posedge clk) begin
    if (rst) begin
      armed = 1; dq.delete(); dq.push_back(6'b0); sv = '0;
      m_db = 0; m_dcnt = 0; m_st = 0; m_scnt = 0; m_pe = 0; m_ncnt = 0;
      m_ps = 0; m_wcnt = 0; m_pcnt = 0;
      e_rst = 1; e_nmi = 0; e_pf = 1; e_cen = 1;
    end else begin
      int  g, e, sl, md, st, b, old_rst, fall, hit;
      g = sv[0]; e = sv[1]; sl = sv[2]; md = sv[3]; st = sv[4]; b = sv[5];
      old_rst = e_rst;
      e_rst = ((md != 0) ? (m_st == 1) : (m_st != 2)) || (m_db != 0) || (m_pcnt != 0);
      e_nmi = (md != 0) ? (m_ncnt != 0) : (e != 0);
      e_pf  = (m_st == 0);
      e_cen = (m_st == 0) ? 1'b1 : cen_in;
      if (b == m_db) m_dcnt = 0;
      else if (m_dcnt == DEB - 1) begin m_db = b; m_dcnt = 0; end
      else m_dcnt++;
      if (m_st == 0) begin if (g != 0) begin m_st = 1; m_scnt = 0; end end
      else if (m_st == 1) begin
        if (g == 0) m_st = 0;
        else if (m_scnt == POR - 1) m_st = 2;
        else m_scnt++;
      end else if (g == 0) m_st = 0;
      if (e != 0 && m_pe == 0) m_ncnt = NMW;
      else if (m_ncnt > 0) m_ncnt--;
      m_pe = e;
      fall = (m_ps != 0 && st == 0);
      m_ps = st;
      hit = 0;
      if (old_rst != 0 || g == 0 || sl != 0 || fall != 0) m_wcnt = 0;
      else if (m_wcnt == WD - 1) begin m_wcnt = 0; hit = 1; end
      else m_wcnt++;
      if (hit != 0) m_pcnt = WRP;
      else if (m_pcnt > 0) m_pcnt--;
      dq.push_back({button, strobe, batt_mode, sleep_req, early_fail, supply_good});
      sv = dq.pop_front();
    end
  end

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (armed) begin
      check_bit({phase, " reset_o"}, reset_o, e_rst);
      check_bit("R1 reset pair", reset_n_o, ~reset_o);
      check_bit({phase, " nmi_o"}, nmi_o, e_nmi);
      check_bit("R10 pfail_o", pfail_o, e_pf);
      check_bit("R1 pfail pair", pfail_n_o, ~pfail_o);
      check_bit("R11 cen_o", cen_o, e_cen);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_window(int n, output int rst_hi, output int nmi_hi);
    rst_hi = 0; nmi_hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (reset_o) rst_hi++;
      if (nmi_o) nmi_hi++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int rh, nh;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    check_bit("R2 reset_o after reset", reset_o, 1'b1);
    check_bit("R2 nmi_o after reset", nmi_o, 1'b0);
    check_bit("R2 pfail_o after reset", pfail_o, 1'b1);
    check_bit("R2 cen_o after reset", cen_o, 1'b1);

    phase = "R3"; kick_en = 1'b1; supply_good = 1'b1;
    count_window(30, rh, nh);
    check_bit("R3 released after stretch", reset_o, 1'b0);

    phase = "R5"; early_fail = 1'b1;
    rh = 0; nh = 0;
    for (int i = 0; i < 25; i++) begin
      if (i == 15) early_fail = 1'b0;
      @(negedge clk);
      if (nmi_o) nh++;
    end
    check_int("R5 nmi level length", nh, 15);

    phase = "R3"; cen_in = 1'b0; supply_good = 1'b0;
    wait_cyc(20);
    check_bit("R3 reset held on loss", reset_o, 1'b1);
    check_bit("R11 cen forced off", cen_o, 1'b1);
    check_bit("R10 pfail on loss", pfail_o, 1'b1);
    supply_good = 1'b1;
    wait_cyc(20);
    check_bit("R11 cen follows input", cen_o, 1'b0);
    check_bit("R3 reset released", reset_o, 1'b0);
    cen_in = 1'b1;

    phase = "R8"; park_level = 1'b1; kick_en = 1'b0;
    count_window(60, rh, nh);
    check_int("R8 watchdog pulse width", rh, WRP);
    kick_en = 1'b1; wait_cyc(10);

    phase = "R7"; park_level = 1'b0; kick_en = 1'b0;
    count_window(60, rh, nh);
    check_int("R7 low level does not restart", rh, WRP);
    park_level = 1'b1; kick_en = 1'b1; wait_cyc(10);

    phase = "R12"; sleep_req = 1'b1; kick_en = 1'b0;
    count_window(120, rh, nh);
    check_int("R12 no reset while sleeping", rh, 0);
    sleep_req = 1'b0; kick_en = 1'b1; wait_cyc(10);

    phase = "R9"; button = 1'b1; wait_cyc(2); button = 1'b0;
    count_window(20, rh, nh);
    check_int("R9 short press ignored", rh, 0);
    rh = 0;
    button = 1'b1;
    for (int i = 0; i < 50; i++) begin
      if (i == 30) button = 1'b0;
      @(negedge clk);
      if (reset_o) rh++;
    end
    check_int("R9 long press length", rh, 30);

    phase = "R6"; batt_mode = 1'b1; wait_cyc(10);
    nh = 0;
    early_fail = 1'b1;
    for (int i = 0; i < 30; i++) begin
      if (i == 20) early_fail = 1'b0;
      @(negedge clk);
      if (nmi_o) nh++;
    end
    check_int("R6 nmi pulse width", nh, NMW);

    phase = "R4"; supply_good = 1'b0;
    count_window(30, rh, nh);
    check_int("R4 no power-down reset", rh, 0);
    check_bit("R10 pfail in battery mode", pfail_o, 1'b1);
    supply_good = 1'b1;
    count_window(30, rh, nh);
    check_int("R4 power-on stretch", rh, POR);
    check_bit("R10 pfail cleared", pfail_o, 1'b0);
    check_bit("R10 pfail_n set", pfail_n_o, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule